// File: doc/BRIEF.md
# Superframe CRC-12 Generator, Checker and Block-Error Counters

This block protects each line superframe with a 12-bit cyclic redundancy check. On the transmit side it runs a CRC over the covered bits of a superframe. It then places the resulting check bits into the check slots of the following superframe. On the receive side it recomputes the CRC over the received covered bits and holds the result until the matching check bits have arrived. It then compares the two. A mismatch is a near-end block error.

A near-end block error is reported back to the far end through the outgoing block-error slot. A zero received in that slot from the far end is counted as a far-end block error. Both error kinds are kept in saturating counters, which a host reads and clears with a single strobe. A corruption control inverts the outgoing check bits, so that the far end sees every block in error.

Neighbouring logic frames the line. For every bit it supplies an enable, a superframe-start strobe and a 2-bit slot code that classifies the bit. Bit alignment and the line code are handled outside this block.

Top module: `superframe_crc_mon`

## Requirements
- R1: Slot codes are 0 = payload, 1 = sync, 2 = check, 3 = block-error flag. The CRC uses generator x^12+x^11+x^3+x^2+x+1 and starts from zero on the bit that carries the superframe-start strobe. It covers the payload and flag bits as they appear at the output, in line order, and never the sync or check bits.
- R2: The first 12 check slots of a transmitted superframe carry the CRC of the previous superframe, most significant coefficient (x^11) first. Any further check slots pass `tx_bit` unchanged. Sync and payload slots pass `tx_bit` unchanged.
- R3: While `tx_corrupt` is 1, every transmitted CRC bit is inverted.
- R4: At a receive superframe start, the CRC of the received data of superframe N is compared with the first 12 check bits received in superframe N+1. No comparison is made at the first two receive starts after reset.
- R5: The transmitted flag slot carries 0 when the most recent comparison mismatched, and 1 otherwise. It is 1 after reset.
- R6: `nebe_count` increases by one for each mismatch. It holds at 2^CNT_W-1 and does not wrap.
- R7: `febe_count` increases by one for each received flag slot that carries 0. It holds at 2^CNT_W-1 and does not wrap.
- R8: `cnt_clear` sets both counters to 0 at the next edge, or to 1 when that counter's event occurs in the same cycle.
- R9: A cycle with `tx_en` or `rx_en` low leaves that side's state unchanged, whatever its strobe, slot and bit inputs are.
- R10: Corrupting a received sync bit causes no block error.
- R11: After reset both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit bit valid |
| tx_sf_start | input | 1 | First transmit bit of a superframe |
| tx_slot | input | 2 | Transmit slot code |
| tx_bit | input | 1 | Transmit bit from the framer |
| tx_corrupt | input | 1 | Invert the outgoing CRC bits |
| tx_out | output | 1 | Transmit bit with check and flag slots filled |
| rx_en | input | 1 | Receive bit valid |
| rx_sf_start | input | 1 | First receive bit of a superframe |
| rx_slot | input | 2 | Receive slot code |
| rx_bit | input | 1 | Received line bit |
| cnt_clear | input | 1 | Read-and-clear strobe for both counters |
| nebe_count | output | CNT_W | Near-end block error count |
| febe_count | output | CNT_W | Far-end block error count |

## Verification
The hardest situation to reach from the ports is a clear strobe that falls in the same cycle as a detected mismatch. The mismatch becomes visible only two superframe starts after the corrupted data. A close second is holding both counters at saturation. The bench loops `tx_out` back into the receive input through an XOR that it controls, so one flipped bit produces a near-end error and then a returned far-end flag. It raises the clear strobe on the exact start bit where a corrupted-check superframe is judged. Several hundred superframes with inverted check bits then drive both counters into their ceiling.

// File: rtl/sfcrc_pkg.sv
`timescale 1ns/1ps
package sfcrc_pkg;

    localparam int                CRC_W    = 12;
    localparam logic [CRC_W-1:0]  CRC_POLY = 12'h80F;   // x^11+x^3+x^2+x+1, x^12 implied
    localparam int                IDX_W    = $clog2(CRC_W + 1);

    typedef enum logic [1:0] {
        SLOT_DATA  = 2'd0,
        SLOT_SYNC  = 2'd1,
        SLOT_CHECK = 2'd2,
        SLOT_FLAG  = 2'd3
    } slot_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic is_covered(input slot_e s);
        return (s == SLOT_DATA) || (s == SLOT_FLAG);
    endfunction

endpackage

// File: rtl/sfcrc_satcnt.sv
`timescale 1ns/1ps
module sfcrc_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = inc ? W'(1) : '0;
        else if (inc && cnt_q != MAX)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R6 / R7: the ceiling is held
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX && !clr) |=> cnt_q == MAX);

    // R6 / R7: at most one step per cycle
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

    // R8: the clear leaves at most one count
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q <= W'(1));

endmodule

// File: rtl/sfcrc_tx.sv
`timescale 1ns/1ps
module sfcrc_tx
    import sfcrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  sf_start,
    input  slot_e slot,
    input  logic  bit_in,
    input  logic  corrupt,
    input  logic  flag_bit,
    output logic  bit_out
);
    typedef struct packed {
        logic [CRC_W-1:0] run;
        logic [CRC_W-1:0] held;
        logic [IDX_W-1:0] idx;
    } tx_st_t;

    tx_st_t st_d, st_q;

    logic [CRC_W-1:0] held_eff, held_sh, run_base;
    logic [IDX_W-1:0] idx_eff;

    always_comb begin
        // Superframe start: the CRC just finished becomes the word to send
        held_eff = (en && sf_start) ? st_q.run : st_q.held;
        idx_eff  = (en && sf_start) ? '0 : st_q.idx;
        run_base = (en && sf_start) ? '0 : st_q.run;
        held_sh  = held_eff << idx_eff;

        unique case (slot)
            SLOT_CHECK: bit_out = (idx_eff < IDX_W'(CRC_W)) ? (held_sh[CRC_W-1] ^ corrupt) : bit_in;
            SLOT_FLAG:  bit_out = flag_bit;
            default:    bit_out = bit_in;
        endcase

        st_d = st_q;
        if (en) begin
            st_d.held = held_eff;
            st_d.run  = is_covered(slot) ? crc_step(run_base, bit_out) : run_base;
            st_d.idx  = (slot == SLOT_CHECK && idx_eff < IDX_W'(CRC_W)) ? idx_eff + IDX_W'(1) : idx_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: idle cycles freeze the transmit state
    a_r9_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q));

    // R2: no more than CRC_W check bits are taken from the held word
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_W'(CRC_W));

endmodule

// File: rtl/sfcrc_rx.sv
`timescale 1ns/1ps
module sfcrc_rx
    import sfcrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  sf_start,
    input  slot_e slot,
    input  logic  bit_in,
    output logic  near_err,
    output logic  far_err,
    output logic  err_flag
);
    typedef struct packed {
        logic [CRC_W-1:0] run;
        logic [CRC_W-1:0] expect_crc;
        logic [CRC_W-1:0] chk;
        logic [IDX_W-1:0] idx;
        logic [1:0]       starts;
        logic             flag;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic             compare;
    logic [CRC_W-1:0] run_base, chk_base;
    logic [IDX_W-1:0] idx_base;

    always_comb begin
        compare  = en && sf_start && (st_q.starts == 2'd2);
        near_err = compare && (st_q.expect_crc != st_q.chk);
        far_err  = en && (slot == SLOT_FLAG) && !bit_in;

        run_base = (en && sf_start) ? '0 : st_q.run;
        chk_base = (en && sf_start) ? '0 : st_q.chk;
        idx_base = (en && sf_start) ? '0 : st_q.idx;

        st_d = st_q;
        if (en) begin
            if (sf_start) begin
                st_d.expect_crc = st_q.run;
                if (st_q.starts != 2'd2) st_d.starts = st_q.starts + 2'd1;
            end
            if (compare) st_d.flag = near_err;
            st_d.run = is_covered(slot) ? crc_step(run_base, bit_in) : run_base;
            st_d.chk = chk_base;
            st_d.idx = idx_base;
            if (slot == SLOT_CHECK && idx_base < IDX_W'(CRC_W)) begin
                st_d.chk = {chk_base[CRC_W-2:0], bit_in};
                st_d.idx = idx_base + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_flag = st_q.flag;

    // R5: the returned flag changes only at a receive superframe start
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && sf_start) |=> $stable(st_q.flag));

    // R9: idle cycles freeze the receive state
    a_r9_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q));

endmodule

// File: rtl/superframe_crc_mon.sv
`timescale 1ns/1ps
module superframe_crc_mon
    import sfcrc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_sf_start,
    input  logic [1:0]       tx_slot,
    input  logic             tx_bit,
    input  logic             tx_corrupt,
    output logic             tx_out,
    input  logic             rx_en,
    input  logic             rx_sf_start,
    input  logic [1:0]       rx_slot,
    input  logic             rx_bit,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] nebe_count,
    output logic [CNT_W-1:0] febe_count
);
    logic near_err, far_err, err_flag;

    sfcrc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .sf_start (tx_sf_start),
        .slot     (slot_e'(tx_slot)),
        .bit_in   (tx_bit),
        .corrupt  (tx_corrupt),
        .flag_bit (!err_flag),
        .bit_out  (tx_out)
    );

    sfcrc_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .sf_start (rx_sf_start),
        .slot     (slot_e'(rx_slot)),
        .bit_in   (rx_bit),
        .near_err (near_err),
        .far_err  (far_err),
        .err_flag (err_flag)
    );

    sfcrc_satcnt #(.W(CNT_W)) u_nebe_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (near_err),
        .cnt   (nebe_count)
    );

    sfcrc_satcnt #(.W(CNT_W)) u_febe_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (far_err),
        .cnt   (febe_count)
    );

    // R5: a transmitted flag slot reports the receive-side verdict
    a_r5_flag_out: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_slot == 2'd3) |-> (tx_out == !err_flag));

endmodule

// File: tb/tb_superframe_crc_mon.sv
`timescale 1ns/1ps
module tb_superframe_crc_mon;

    localparam int SF_LEN = 40;
    localparam int CMAX   = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, sfs = 1'b0, tbit = 1'b0, cor = 1'b0, clr = 1'b0, flip = 1'b0;
    logic [1:0] slot = 2'd1;
    logic       tx_out, rx_bit;
    logic [7:0] nebe_count, febe_count;

    assign rx_bit = tx_out ^ flip;

    always #4 clk = ~clk;

    superframe_crc_mon dut (
        .clk(clk), .rst_n(rst_n),
        .tx_en(en), .tx_sf_start(sfs), .tx_slot(slot), .tx_bit(tbit), .tx_corrupt(cor), .tx_out(tx_out),
        .rx_en(en), .rx_sf_start(sfs), .rx_slot(slot), .rx_bit(rx_bit),
        .cnt_clear(clr), .nebe_count(nebe_count), .febe_count(febe_count)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    bit t_q[$];
    bit r_q[$];
    int t_held = 0, t_idx = 0;
    int r_exp = 0, r_chk = 0, r_idx = 0, r_starts = 0;
    bit m_flag = 0;
    int m_nebe = 0, m_febe = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // remainder of message * x^12 divided by the generator
    function automatic int crc_of(input bit q[$]);
        int n = q.size();
        bit a[] = new[n + 12];
        int r = 0;
        bit [12:0] gen = 13'h180F;
        for (int i = 0; i < n + 12; i++) a[i] = (i < n) ? q[i] : 1'b0;
        for (int i = 0; i < n; i++)
            if (a[i]) for (int j = 0; j <= 12; j++) a[i+j] ^= gen[12-j];
        for (int k = 0; k < 12; k++) r = (r << 1) | int'(a[n+k]);
        return r;
    endfunction

    function automatic logic [1:0] slot_of(input int p);
        if (p < 4)  return 2'd1;
        if (p < 20) return 2'd0;
        if (p < 32) return 2'd2;
        if (p == 32) return 2'd3;
        return 2'd0;
    endfunction

    task automatic step(input bit e, input bit s, input logic [1:0] sl, input bit b,
                        input bit c, input bit cl, input bit fl);
        int held_eff, idx_eff;
        bit exp_tx, rb, ne, fe;
        string tag;
        @(negedge clk);
        en = e; sfs = s; slot = sl; tbit = b; cor = c; clr = cl; flip = fl;
        #1;
        held_eff = (e && s) ? crc_of(t_q) : t_held;
        idx_eff  = (e && s) ? 0 : t_idx;
        if (sl == 2'd2 && idx_eff < 12) begin
            exp_tx = bit'((held_eff >> (11 - idx_eff)) & 1) ^ c;
            tag = c ? "R3 corrupt check bit" : "R2 check bit";
        end else if (sl == 2'd3) begin
            exp_tx = !m_flag;
            tag = "R5 flag slot";
        end else begin
            exp_tx = b;
            tag = "R2 pass-through";
        end
        chk(tag, int'(tx_out), int'(exp_tx));
        chk("R6 nebe_count", int'(nebe_count), m_nebe);
        chk("R7 febe_count", int'(febe_count), m_febe);
        @(posedge clk);
        rb = exp_tx ^ fl;
        ne = 0; fe = 0;
        if (e) begin
            if (s) begin
                t_held = held_eff; t_q.delete(); t_idx = 0;
                if (r_starts >= 2) begin ne = (r_exp != r_chk); m_flag = ne; end
                r_exp = crc_of(r_q); r_q.delete(); r_chk = 0; r_idx = 0;
                if (r_starts < 2) r_starts++;
            end
            if (sl == 2'd0 || sl == 2'd3) begin t_q.push_back(exp_tx); r_q.push_back(rb); end
            if (sl == 2'd2 && t_idx < 12) t_idx++;
            if (sl == 2'd2 && r_idx < 12) begin r_chk = ((r_chk << 1) | int'(rb)) & 'hFFF; r_idx++; end
            if (sl == 2'd3 && !rb) fe = 1;
        end
        if (cl) begin m_nebe = ne ? 1 : 0; m_febe = fe ? 1 : 0; end
        else begin
            if (ne && m_nebe < CMAX) m_nebe++;
            if (fe && m_febe < CMAX) m_febe++;
        end
    endtask

    task automatic run_sf(input int flip_at, input bit c, input bit clr_first, input int idle_at);
        for (int p = 0; p < SF_LEN; p++) begin
            if (p == idle_at)
                for (int k = 0; k < 3; k++) step(0, k == 0, 2'(k), bit'($urandom % 2), c, 0, 1);
            step(1, p == 0, slot_of(p), (p < 4) ? bit'(p != 2) : bit'($urandom % 2),
                 c, clr_first && p == 0, p == flip_at);
        end
    endtask

    task automatic idle_sample();
        @(negedge clk);
        en = 0; sfs = 0; clr = 0; flip = 0; cor = 0;
        #1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base_n, base_f;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R11 reset nebe", int'(nebe_count), 0);
        chk("R11 reset febe", int'(febe_count), 0);

        // clean loopback
        for (int i = 0; i < 5; i++) run_sf(-1, 0, 0, -1);
        idle_sample();
        chk("R1 clean loopback nebe", int'(nebe_count), 0);
        chk("R4 clean loopback febe", int'(febe_count), 0);

        // one flipped payload bit
        run_sf(10, 0, 0, -1);
        run_sf(-1, 0, 0, -1);
        run_sf(-1, 0, 0, -1);
        idle_sample();
        chk("R4 payload error detected", int'(nebe_count), 1);
        chk("R5 flag returned and counted R7", int'(febe_count), 1);

        // flipped sync bit, idle cycles inside a superframe
        base_n = m_nebe;
        run_sf(2, 0, 0, -1);
        run_sf(-1, 0, 0, 15);
        run_sf(-1, 0, 0, 25);
        run_sf(-1, 0, 0, -1);
        idle_sample();
        chk("R10 sync flip harmless", int'(nebe_count), base_n);
        chk("R9 idle cycles harmless", int'(nebe_count), m_nebe);

        // flipped check bit
        run_sf(-1, 0, 0, -1);
        run_sf(25, 0, 0, -1);
        run_sf(-1, 0, 0, -1);
        run_sf(-1, 0, 0, -1);
        idle_sample();
        chk("R4 check bit error", int'(nebe_count), base_n + 1);

        // corrupt mode, then a clear on a judged start
        run_sf(-1, 1, 0, -1);
        run_sf(-1, 0, 1, -1);
        idle_sample();
        chk("R8 clear with coincident event", int'(nebe_count), 1);
        chk("R8 clear febe", int'(febe_count), m_febe);
        run_sf(-1, 0, 1, -1);
        run_sf(-1, 0, 0, -1);
        idle_sample();
        chk("R8 clear plain", int'(nebe_count), 0);
        chk("R3 corrupt model agreement", int'(febe_count), m_febe);

        // saturation
        for (int i = 0; i < 265; i++) run_sf(-1, 1, 0, -1);
        idle_sample();
        chk("R6 nebe saturates", int'(nebe_count), CMAX);
        chk("R7 febe saturates", int'(febe_count), CMAX);
        base_f = m_febe;
        run_sf(-1, 1, 0, -1);
        idle_sample();
        chk("R6 nebe holds at ceiling", int'(nebe_count), CMAX);
        chk("R7 febe holds at ceiling", int'(febe_count), base_f);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule